// File: doc/BRIEF.md
# Double-Buffered Host DMA Read Port

This block sits on the slave side of a host link. It carries 32-bit words from local logic out to an external DMA controller. Local logic, or an on-chip DMA engine, writes a word into a holding register. Whenever the host-visible receive register is empty and the holding register has data, the port moves the word across one clock later. This refills the receive register and frees the holding register. The holding-empty flag is a service request output, so the local side can keep the two-stage pipeline full.

The external controller uses only a request line and an acknowledge strobe, with no address. The port pulls its active-low request down while the receive register holds a word and read requests are enabled. The controller then pulls the active-low acknowledge down. While acknowledge is low, the port drives the receive register onto the data bus. The read completes when acknowledge rises. That edge empties the receive register and withdraws the request. A local write into a full holding register is dropped and recorded. An acknowledge that arrives while the receive register is empty is also recorded, and it leaves the flags untouched.

Top module: `hdma_read_port`

## Requirements
- R1: After reset, `hreq_n` is 1, `rx_full` is 0, `hold_empty` is 1, `ovr_err` and `und_err` are 0, `hdata` is 0, and both enable bits are 0.
- R2: A `loc_wr` pulse sampled while `hold_empty` is 1 stores `loc_wdata` in the holding register, and `hold_empty` reads 0 after that clock edge.
- R3: When `rx_full` is 0 and `hold_empty` is 0, the next clock edge copies the holding word into the receive register, so `rx_full` becomes 1, `hold_empty` becomes 1, and `hdata` shows the word.
- R4: `hreq_n` is 0 exactly when `rx_full` is 1, the read-request enable is 1 and the write-request enable is 0; otherwise it is 1.
- R5: While `hack_n` is 0, `hdata_oe` is 1 and `hdata` carries the receive word. The clock edge that first samples `hack_n` high again after a valid read clears `rx_full`, and `hreq_n` goes to 1.
- R6: A `loc_wr` pulse sampled while `hold_empty` is 0 leaves the holding word unchanged and sets `ovr_err`. `ovr_err` then stays 1 until reset.
- R7: A falling `hack_n` sampled while `rx_full` is 0 sets `und_err`, which is sticky. `hdata` keeps its last value, and neither flag changes because of that access.
- R8: Words written locally reach the host in write order, with none lost and none repeated, for any spacing of writes and acknowledges.
- R9: A `cfg_wr` pulse loads `cfg_rd_req_en` and `cfg_wr_req_en` into the two enable bits on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loc_wr | input | 1 | Local write strobe for the holding register |
| loc_wdata | input | DATA_W | Local write data |
| cfg_wr | input | 1 | Load strobe for the enable bits |
| cfg_rd_req_en | input | 1 | Read-request enable value |
| cfg_wr_req_en | input | 1 | Write-request enable value |
| hack_n | input | 1 | Host acknowledge, active low |
| hreq_n | output | 1 | DMA request to host, active low |
| hdata | output | DATA_W | Receive register contents |
| hdata_oe | output | 1 | Data bus drive enable, high while acknowledge is low |
| rx_full | output | 1 | Receive register holds an unread word |
| hold_empty | output | 1 | Holding register free; local service request |
| ovr_err | output | 1 | Sticky: write to a full holding register |
| und_err | output | 1 | Sticky: acknowledge with an empty receive register |

## Verification
A wrong flag shows up at the ports within one or two clocks. A stuck `rx_full` either holds `hreq_n` low after a completed read or never lowers it again after a move. A stale `hold_empty` lets a write slip past the overrun guard, and that is visible as a duplicated or missing word in the in-order stream. A receive register that loads at the wrong time appears on `hdata` during the very next acknowledge. A failed move stalls the stream, and the bench catches that through its missing-word count.

// File: rtl/hdp_pkg.sv
package hdp_pkg;
   typedef struct packed {
      logic rd_en;
      logic wr_en;
   } hdp_cfg_t;

   localparam hdp_cfg_t HDP_CFG_RESET = '{rd_en: 1'b0, wr_en: 1'b0};
endpackage

// File: rtl/hdp_hold_stage.sv
module hdp_hold_stage #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              take_i,
   output logic [DATA_W-1:0] data_o,
   output logic              empty_o,
   output logic              ovr_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o  <= '0;
         empty_o <= 1'b1;
         ovr_o   <= 1'b0;
      end else begin
         if (wr_i && empty_o) begin
            data_o  <= wdata_i;
            empty_o <= 1'b0;
         end else if (wr_i) begin
            ovr_o <= 1'b1;
         end
         if (take_i) begin
            empty_o <= 1'b1;
         end
      end
   end

   AST_HOLD_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !empty_o) |=> $stable(data_o)); // R6
   AST_HOLD_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_o |=> ovr_o); // R6
   AST_HOLD_TAKE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |-> !empty_o); // R3
   AST_HOLD_WR_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && empty_o) |=> !empty_o); // R2
endmodule

// File: rtl/hdp_rx_stage.sv
module hdp_rx_stage #(
   parameter int DATA_W   = 32,
   parameter int ACK_SYNC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ack_n_i,
   input  logic              load_i,
   input  logic [DATA_W-1:0] ldata_i,
   output logic [DATA_W-1:0] data_o,
   output logic              full_o,
   output logic              und_o
);
   logic ack_s;
   logic ack_q;
   logic rd_valid;
   logic ack_fall;
   logic ack_rise;

   generate
      if (ACK_SYNC == 0) begin : g_direct
         assign ack_s = ack_n_i;
      end else begin : g_sync
         logic [ACK_SYNC-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '1;
            else        sh <= {sh[ACK_SYNC-2:0], ack_n_i};
         end
         assign ack_s = sh[ACK_SYNC-1];
      end
   endgenerate

   assign ack_fall = !ack_s && ack_q;
   assign ack_rise = ack_s && !ack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q    <= 1'b1;
         rd_valid <= 1'b0;
         data_o   <= '0;
         full_o   <= 1'b0;
         und_o    <= 1'b0;
      end else begin
         ack_q <= ack_s;
         if (ack_fall) begin
            rd_valid <= full_o;
            if (!full_o) und_o <= 1'b1;
         end
         if (ack_rise) begin
            rd_valid <= 1'b0;
         end
         if (ack_rise && rd_valid) begin
            full_o <= 1'b0;
         end else if (load_i) begin
            full_o <= 1'b1;
            data_o <= ldata_i;
         end
      end
   end

   AST_RX_LOAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> !full_o); // R3
   AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rise && rd_valid) |=> !full_o); // R5
   AST_RX_UND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      und_o |=> und_o); // R7
   AST_RX_UND_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_fall && !full_o && !load_i) |=> (!full_o && $stable(data_o))); // R7
endmodule

// File: rtl/hdp_req_ctl.sv
module hdp_req_ctl
   import hdp_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cfg_wr_i,
   input  hdp_cfg_t cfg_i,
   input  logic     full_i,
   output logic     req_n_o
);
   hdp_cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg_q <= HDP_CFG_RESET;
      else if (cfg_wr_i) cfg_q <= cfg_i;
   end

   assign req_n_o = !(full_i && cfg_q.rd_en && !cfg_q.wr_en);

   AST_REQ_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_i && !cfg_i.rd_en) |=> req_n_o); // R9
   AST_REQ_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !full_i |-> req_n_o); // R4
endmodule

// File: rtl/hdma_read_port.sv
module hdma_read_port
   import hdp_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ACK_SYNC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              loc_wr,
   input  logic [DATA_W-1:0] loc_wdata,
   input  logic              cfg_wr,
   input  logic              cfg_rd_req_en,
   input  logic              cfg_wr_req_en,
   input  logic              hack_n,
   output logic              hreq_n,
   output logic [DATA_W-1:0] hdata,
   output logic              hdata_oe,
   output logic              rx_full,
   output logic              hold_empty,
   output logic              ovr_err,
   output logic              und_err
);
   initial begin
      AST_CFG_WIDTH: assert (DATA_W >= 1) else $error("DATA_W must be positive"); // R1
      AST_CFG_SYNC: assert (ACK_SYNC == 0 || ACK_SYNC >= 2)
         else $error("ACK_SYNC must be 0 or at least 2"); // R5
   end

   logic [DATA_W-1:0] hold_data;
   logic              move;
   hdp_cfg_t          cfg_in;

   assign move     = !hold_empty && !rx_full;
   assign hdata_oe = !hack_n;
   assign cfg_in   = '{rd_en: cfg_rd_req_en, wr_en: cfg_wr_req_en};

   hdp_hold_stage #(.DATA_W(DATA_W)) i_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (loc_wr),
      .wdata_i (loc_wdata),
      .take_i  (move),
      .data_o  (hold_data),
      .empty_o (hold_empty),
      .ovr_o   (ovr_err)
   );

   hdp_rx_stage #(.DATA_W(DATA_W), .ACK_SYNC(ACK_SYNC)) i_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .ack_n_i (hack_n),
      .load_i  (move),
      .ldata_i (hold_data),
      .data_o  (hdata),
      .full_o  (rx_full),
      .und_o   (und_err)
   );

   hdp_req_ctl i_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr_i (cfg_wr),
      .cfg_i    (cfg_in),
      .full_i   (rx_full),
      .req_n_o  (hreq_n)
   );

   AST_MOVE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_full && !hold_empty) |=> (rx_full && hold_empty)); // R3
   AST_MOVE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_full && !hold_empty) |=> (hdata == $past(hold_data))); // R8
endmodule

// File: tb/test_hdma_read_port.sv
`timescale 1ns/1ps
module test_hdma_read_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        loc_wr = 1'b0;
   logic [31:0] loc_wdata = '0;
   logic        cfg_wr = 1'b0;
   logic        cfg_rd_req_en = 1'b0;
   logic        cfg_wr_req_en = 1'b0;
   logic        hack_n = 1'b1;
   logic        hreq_n;
   logic [31:0] hdata;
   logic        hdata_oe;
   logic        rx_full;
   logic        hold_empty;
   logic        ovr_err;
   logic        und_err;

   int total = 0;
   int bad = 0;
   localparam int NWORDS = 80;

   always #2 clk = !clk;

   hdma_read_port i_hdma_read_port (
      .clk(clk), .rst_n(rst_n), .loc_wr(loc_wr), .loc_wdata(loc_wdata),
      .cfg_wr(cfg_wr), .cfg_rd_req_en(cfg_rd_req_en), .cfg_wr_req_en(cfg_wr_req_en),
      .hack_n(hack_n), .hreq_n(hreq_n), .hdata(hdata), .hdata_oe(hdata_oe),
      .rx_full(rx_full), .hold_empty(hold_empty), .ovr_err(ovr_err), .und_err(und_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] stream_word(input int k);
      return 32'(k) * 32'h9E37_79B9 + 32'h1357_0000;
   endfunction

   task automatic do_write(input logic [31:0] d);
      @(negedge clk);
      loc_wr = 1'b1;
      loc_wdata = d;
      @(negedge clk);
      loc_wr = 1'b0;
   endtask

   task automatic set_cfg(input logic rd, input logic wr);
      @(negedge clk);
      cfg_wr = 1'b1;
      cfg_rd_req_en = rd;
      cfg_wr_req_en = wr;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic do_read(output logic [31:0] d);
      @(negedge clk);
      hack_n = 1'b0;
      @(negedge clk);
      chk("R5 oe", 32'(hdata_oe), 32'd1);
      d = hdata;
      hack_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [31:0] rd;
      int          got;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 hreq_n", 32'(hreq_n), 32'd1);
      chk("R1 rx_full", 32'(rx_full), 32'd0);
      chk("R1 hold_empty", 32'(hold_empty), 32'd1);
      chk("R1 ovr", 32'(ovr_err), 32'd0);
      chk("R1 und", 32'(und_err), 32'd0);
      chk("R1 hdata", hdata, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      do_write(32'hA5A5_0001);
      chk("R2 hold_empty", 32'(hold_empty), 32'd0);
      @(negedge clk);
      chk("R3 rx_full", 32'(rx_full), 32'd1);
      chk("R3 hold_empty", 32'(hold_empty), 32'd1);
      chk("R3 hdata", hdata, 32'hA5A5_0001);
      chk("R1 enables off hreq_n", 32'(hreq_n), 32'd1);

      set_cfg(1'b1, 1'b0);
      chk("R9 R4 req on", 32'(hreq_n), 32'd0);
      set_cfg(1'b1, 1'b1);
      chk("R4 wr enable blocks", 32'(hreq_n), 32'd1);
      set_cfg(1'b1, 1'b0);

      do_write(32'hB0B0_0002);
      chk("R2 hold_empty B", 32'(hold_empty), 32'd0);
      do_write(32'hC0C0_0003);
      chk("R6 ovr set", 32'(ovr_err), 32'd1);
      chk("R6 hold still full", 32'(hold_empty), 32'd0);

      do_read(rd);
      chk("R5 read A", rd, 32'hA5A5_0001);
      chk("R5 rx cleared", 32'(rx_full), 32'd0);
      chk("R5 req released", 32'(hreq_n), 32'd1);
      @(negedge clk);
      chk("R3 refill rx_full", 32'(rx_full), 32'd1);
      chk("R3 refill hold_empty", 32'(hold_empty), 32'd1);
      chk("R4 req again", 32'(hreq_n), 32'd0);

      do_read(rd);
      chk("R6 dropped word not seen", rd, 32'hB0B0_0002);
      @(negedge clk);
      chk("R5 empty after B", 32'(rx_full), 32'd0);

      // R7 underrun
      hack_n = 1'b0;
      @(negedge clk);
      chk("R7 und set", 32'(und_err), 32'd1);
      chk("R7 last value", hdata, 32'hB0B0_0002);
      chk("R7 rx_full kept", 32'(rx_full), 32'd0);
      chk("R7 hold_empty kept", 32'(hold_empty), 32'd1);
      hack_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R7 rx_full after", 32'(rx_full), 32'd0);
      chk("R7 req idle", 32'(hreq_n), 32'd1);
      chk("R7 und sticky", 32'(und_err), 32'd1);
      do_write(32'hD0D0_0004);
      @(negedge clk);
      do_read(rd);
      chk("R7 next word intact", rd, 32'hD0D0_0004);
      chk("R6 ovr sticky", 32'(ovr_err), 32'd1);

      // R8 stream
      got = 0;
      fork
         begin
            for (int k = 0; k < NWORDS; k++) begin
               repeat ($urandom_range(0, 6)) @(negedge clk);
               do @(negedge clk); while (!hold_empty);
               do_write(stream_word(k));
            end
         end
         begin
            for (int k = 0; k < NWORDS; k++) begin
               do @(negedge clk); while (hreq_n);
               repeat ($urandom_range(0, 5)) @(negedge clk);
               do_read(rd);
               chk("R8 stream order", rd, stream_word(k));
               got++;
            end
         end
      join
      repeat (4) @(negedge clk);
      chk("R8 word count", 32'(got), 32'(NWORDS));
      chk("R8 drained rx", 32'(rx_full), 32'd0);
      chk("R8 drained hold", 32'(hold_empty), 32'd1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule